// File: doc/BRIEF.md
# Four-Channel Register-Programmed Memory Copy Engine

This block copies blocks of elements from one memory location to another on behalf of software. It has four channels. Each channel is set up through a small word-wide configuration port that holds a control word, an element count, and 64-bit source, destination and list-pointer addresses. A channel starts when its control word is written with the enable bit set. The engine then moves the elements over a single-beat memory master port. For each element it does one read and then one write, and it waits for the memory's ready on every beat.

The element width is 1, 2, 4 or 8 bytes. The source address and the destination address each either step by the element width or stay fixed, so a fixed-address port can be filled or drained. Only one channel runs at a time. When several channels are enabled, the lowest-numbered one goes first. When a channel finishes, its enable bit clears and its done flag rises in a shared status word.

The sequencer has four states. S_IDLE picks the highest-priority enabled channel and captures its settings. From there it goes to S_FINISH when the count is zero, or to S_READ otherwise. S_READ issues a read and, on ready, latches the element and goes to S_WRITE. S_WRITE issues the write and, on ready, steps the addresses and decrements the remaining count. It then goes back to S_READ, or to S_FINISH after the last element. S_FINISH lasts one cycle, reports completion to the register file and returns to S_IDLE.

Top module: `dma4_engine`

## Requirements
- R1: Configuration word offsets place channel c at offset 8*c + k. The slot k is 0 control, 1 count, 2 source bits 63:32, 3 source bits 31:0, 4 destination bits 63:32, 5 destination bits 31:0, 6 list pointer bits 63:32 and 7 list pointer bits 31:0. The shared registers are at offsets 32 (status), 33 (list command), 34 (sleep) and 35 (polarity). Every register except status reads back what was last written.
- R2: A write to an upper-word slot replaces only bits 63:32 of that address and leaves the lower word unchanged. A write to a lower-word slot replaces only bits 31:0.
- R3: A control write with bit 31 set starts the channel. A control write with bit 31 clear causes no memory traffic and sets no done flag.
- R4: Control bits 26:25 hold a code f, and the element width is 2^f bytes. mem_size carries f on every beat. Elements travel little-endian in the low 2^f bytes of the data buses: the byte at the lowest address sits in bits 7:0. Write lanes above the element are zero.
- R5: Control bit 24 set makes the destination address advance by the element width after each element. Bit 23 does the same for the source address. When its bit is clear, an address stays fixed.
- R6: Only bits 15:0 of the count register give the element count. A count of zero causes no memory beat, but the channel still completes as in R9.
- R7: Each element takes one read beat followed by one write beat. mem_addr, mem_we and mem_wdata stay stable while mem_req is high and mem_ready is low.
- R8: Only one channel is serviced at a time. Among the enabled channels, the lowest-numbered one is taken next.
- R9: On completion, bit 31 of the channel's control word clears and its other bits are kept. Status bit c (for channel c) sets. Writing a 1 to a status bit clears it.
- R10: After reset every register reads zero and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write (1) or a read (0) |
| mem_addr | output | 64 | Byte address of the beat |
| mem_size | output | 2 | Element width code f, width 2^f bytes |
| mem_wdata | output | 64 | Write data, element in the low lanes |
| mem_rdata | input | 64 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts or completes the current beat |

## Verification
The assertions assume that software does not write the registers of the channel being serviced, and that mem_ready is high only while mem_req is high. The stimulus respects both. Every random or directed transfer is set up before its control write, and the only writes made during a run go to idle channels. The bench memory raises ready for exactly one cycle, after a random wait, and only in answer to a pending request. It also fills the read lanes above the element with random bytes, so that any failure to mask them shows up on the write beat.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int SLOTS_PER_CH = 8;
    localparam int ENABLE_BIT   = 31;
    localparam int DST_INC_BIT  = 24;
    localparam int SRC_INC_BIT  = 23;
    localparam int WIDTH_LSB    = 25;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_FINISH
    } mv_state_e;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [15:0] cnt;
        logic [63:0] src;
        logic [63:0] dst;
    } chan_cfg_t;

    function automatic logic [63:0] lane_mask(input logic [1:0] code);
        lane_mask = (code == 2'd3) ? {64{1'b1}} : ((64'd1 << (8 << code)) - 64'd1);
    endfunction
endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CFG_AW = 6,
    parameter int CH_W   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o,
    output logic [NUM_CH-1:0]        pend,
    input  logic                     fin_valid,
    input  logic [CH_W-1:0]          fin_ch
);
    localparam int BASE_COMMON = NUM_CH * SLOTS_PER_CH;
    localparam int OFF_STAT = BASE_COMMON;
    localparam int OFF_SGC  = BASE_COMMON + 1;
    localparam int OFF_SLP  = BASE_COMMON + 2;
    localparam int OFF_POL  = BASE_COMMON + 3;

    logic [NUM_CH-1:0][31:0] ctrl_v;
    logic [NUM_CH-1:0][15:0] cnt_v;
    logic [NUM_CH-1:0][31:0] cnt_full_v;
    logic [NUM_CH-1:0][63:0] src_v, dst_v, sg_v;
    logic [NUM_CH-1:0]       status_q, fin_set, stat_clr;
    logic [31:0]             sgc_q, slp_q, pol_q;
    logic [2:0]              slot;

    assign slot = cfg_addr[2:0];

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_ch
            logic [31:0] ctrl_q, cnt_q;
            logic [63:0] src_q, dst_q, sg_q;
            logic        hit;
            assign hit = cfg_we && (cfg_addr[CFG_AW-1:3] == (CFG_AW-3)'(c));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ctrl_q <= '0; cnt_q <= '0; src_q <= '0; dst_q <= '0; sg_q <= '0;
                end else begin
                    if (fin_valid && fin_ch == CH_W'(c))
                        ctrl_q[ENABLE_BIT] <= 1'b0;
                    else if (hit && slot == 3'd0)
                        ctrl_q <= cfg_wdata;
                    if (hit) begin
                        case (slot)
                            3'd1: cnt_q <= cfg_wdata;
                            3'd2: src_q[63:32] <= cfg_wdata;
                            3'd3: src_q[31:0]  <= cfg_wdata;
                            3'd4: dst_q[63:32] <= cfg_wdata;
                            3'd5: dst_q[31:0]  <= cfg_wdata;
                            3'd6: sg_q[63:32]  <= cfg_wdata;
                            3'd7: sg_q[31:0]   <= cfg_wdata;
                            default: ;
                        endcase
                    end
                end
            end

            assign ctrl_v[c]     = ctrl_q;
            assign cnt_full_v[c] = cnt_q;
            assign cnt_v[c]      = cnt_q[15:0];
            assign src_v[c]      = src_q;
            assign dst_v[c]      = dst_q;
            assign sg_v[c]       = sg_q;
            assign pend[c]       = ctrl_q[ENABLE_BIT];
            assign cfg_o[c]      = '{ctrl: ctrl_q, cnt: cnt_q[15:0], src: src_q, dst: dst_q};
            assign fin_set[c]    = fin_valid && (fin_ch == CH_W'(c));

            // R9: a channel reported finished must have been enabled
            a_r9_fin_was_enabled: assert property (@(posedge clk) disable iff (!rst_n)
                fin_set[c] |-> ctrl_q[ENABLE_BIT]);
            // R9: completion clears the enable and raises the done flag
            a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
                fin_set[c] |=> (!ctrl_q[ENABLE_BIT] && status_q[c]));
        end
    endgenerate

    assign stat_clr = (cfg_we && cfg_addr == CFG_AW'(OFF_STAT)) ? cfg_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0; sgc_q <= '0; slp_q <= '0; pol_q <= '0;
        end else begin
            status_q <= (status_q & ~stat_clr) | fin_set;
            if (cfg_we && cfg_addr == CFG_AW'(OFF_SGC)) sgc_q <= cfg_wdata;
            if (cfg_we && cfg_addr == CFG_AW'(OFF_SLP)) slp_q <= cfg_wdata;
            if (cfg_we && cfg_addr == CFG_AW'(OFF_POL)) pol_q <= cfg_wdata;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (int'(cfg_addr) < BASE_COMMON) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (cfg_addr[CFG_AW-1:3] == (CFG_AW-3)'(i)) begin
                    case (slot)
                        3'd0: cfg_rdata = ctrl_v[i];
                        3'd1: cfg_rdata = cnt_full_v[i];
                        3'd2: cfg_rdata = src_v[i][63:32];
                        3'd3: cfg_rdata = src_v[i][31:0];
                        3'd4: cfg_rdata = dst_v[i][63:32];
                        3'd5: cfg_rdata = dst_v[i][31:0];
                        3'd6: cfg_rdata = sg_v[i][63:32];
                        default: cfg_rdata = sg_v[i][31:0];
                    endcase
                end
            end
        end else if (cfg_addr == CFG_AW'(OFF_STAT)) cfg_rdata = 32'(status_q);
        else if (cfg_addr == CFG_AW'(OFF_SGC)) cfg_rdata = sgc_q;
        else if (cfg_addr == CFG_AW'(OFF_SLP)) cfg_rdata = slp_q;
        else if (cfg_addr == CFG_AW'(OFF_POL)) cfg_rdata = pol_q;
    end

    logic unused_cnt;
    assign unused_cnt = ^cnt_v;
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  chan_cfg_t [NUM_CH-1:0]  cfg_i,
    input  logic [NUM_CH-1:0]       pend,
    output logic                    fin_valid,
    output logic [CH_W-1:0]         fin_ch,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [63:0]             mem_addr,
    output logic [1:0]              mem_size,
    output logic [63:0]             mem_wdata,
    input  logic [63:0]             mem_rdata,
    input  logic                    mem_ready
);
    mv_state_e   state, state_n;
    logic        pick_any;
    logic [CH_W-1:0] pick_ch, cur_ch;
    chan_cfg_t   sel;
    logic [63:0] w_src, w_dst, data_q, step;
    logic [15:0] w_left;
    logic [1:0]  w_code;
    logic        inc_s, inc_d;

    // fixed priority: lowest index wins
    always_comb begin
        pick_any = 1'b0;
        pick_ch  = '0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (pend[c]) begin
                pick_any = 1'b1;
                pick_ch  = CH_W'(c);
            end
        end
        sel = cfg_i[pick_ch];
    end

    assign step = 64'd1 << w_code;

    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:   if (pick_any) state_n = (sel.cnt == 16'd0) ? S_FINISH : S_READ;
            S_READ:   if (mem_ready) state_n = S_WRITE;
            S_WRITE:  if (mem_ready) state_n = (w_left == 16'd1) ? S_FINISH : S_READ;
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch <= '0; w_src <= '0; w_dst <= '0; w_left <= '0;
            w_code <= '0; inc_s <= 1'b0; inc_d <= 1'b0; data_q <= '0;
        end else begin
            if (state == S_IDLE && pick_any) begin
                cur_ch <= pick_ch;
                w_src  <= sel.src;
                w_dst  <= sel.dst;
                w_left <= sel.cnt;
                w_code <= sel.ctrl[WIDTH_LSB+1:WIDTH_LSB];
                inc_s  <= sel.ctrl[SRC_INC_BIT];
                inc_d  <= sel.ctrl[DST_INC_BIT];
            end
            if (state == S_READ && mem_ready)
                data_q <= mem_rdata & lane_mask(w_code);
            if (state == S_WRITE && mem_ready) begin
                w_left <= w_left - 16'd1;
                if (inc_s) w_src <= w_src + step;
                if (inc_d) w_dst <= w_dst + step;
            end
        end
    end

    always_comb begin
        mem_req   = (state == S_READ) || (state == S_WRITE);
        mem_we    = (state == S_WRITE);
        mem_addr  = (state == S_WRITE) ? w_dst : w_src;
        mem_size  = w_code;
        mem_wdata = data_q;
        fin_valid = (state == S_FINISH);
        fin_ch    = cur_ch;
    end

    // R7: a beat is held unchanged until memory accepts it
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R7: an accepted read is followed by the write of that element
    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=> (mem_req && mem_we));
    // R4: write lanes above the element width carry zero
    a_r4_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ((mem_wdata & ~lane_mask(mem_size)) == 64'd0));
    // R6: a zero-count launch issues no beat
    a_r6_zero_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && pick_any && sel.cnt == 16'd0) |=> !mem_req);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CFG_AW = $clog2(NUM_CH * SLOTS_PER_CH + 4),
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [63:0]       mem_addr,
    output logic [1:0]        mem_size,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ready
);
    chan_cfg_t [NUM_CH-1:0] ch_cfg;
    logic [NUM_CH-1:0]      pend;
    logic                   fin_valid;
    logic [CH_W-1:0]        fin_ch;

    dma4_regs #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_o(ch_cfg),
        .pend(pend), .fin_valid(fin_valid), .fin_ch(fin_ch)
    );

    dma4_mover #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .cfg_i(ch_cfg), .pend(pend),
        .fin_valid(fin_valid), .fin_ch(fin_ch), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );
endmodule

// File: tb/tb_dma4_engine.sv
`timescale 1ns/100ps
module tb_dma4_engine;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        mem_req, mem_we, mem_ready = 1'b0;
    logic [63:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [1:0]  mem_size;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [7:0] mem [4096];
    logic [7:0] expm [4096];

    // memory monitor state
    int acc_cnt = 0, mon_err = 0, wait_cnt = 0;
    bit exp_we = 0, mon_on = 0, mon_hi = 0;
    logic [1:0]  exp_code = 0;
    logic [31:0] mon_shi = 0, mon_dhi = 0;
    logic [63:0] last_wdata = 0;

    always #2.5 clk = ~clk;

    dma4_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    function automatic logic [63:0] lmask(input logic [1:0] code);
        lmask = (code == 2'd3) ? {64{1'b1}} : ((64'd1 << (8 << code)) - 64'd1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory responder and beat monitor
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ready) mem_ready = 1'b0;
            else if (mem_req) begin
                if (wait_cnt == 0) begin
                    int w;
                    int a;
                    w = 1 << mem_size;
                    a = int'(mem_addr[11:0]);
                    acc_cnt++;
                    if (mem_we !== exp_we) mon_err++;
                    exp_we = ~exp_we;
                    if (mon_on && mem_size !== exp_code) mon_err++;
                    if (mon_hi && mem_addr[63:32] !== (mem_we ? mon_dhi : mon_shi)) mon_err++;
                    if (mem_we) begin
                        if ((mem_wdata & ~lmask(mem_size)) != 64'd0) mon_err++;
                        last_wdata = mem_wdata;
                        for (int k = 0; k < w; k++) mem[(a + k) & 12'hfff] = mem_wdata[8*k +: 8];
                    end else begin
                        mem_rdata = {$urandom, $urandom};
                        for (int k = 0; k < w; k++) mem_rdata[8*k +: 8] = mem[(a + k) & 12'hfff];
                    end
                    mem_ready = 1'b1;
                    wait_cnt = $urandom % 3;
                end else wait_cnt--;
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = 6'(a);
        #1 d = cfg_rdata;
    endtask

    task automatic setup(input int c, input logic [63:0] s, input logic [63:0] d, input logic [31:0] cnt);
        wr(c*8+1, cnt);
        wr(c*8+2, s[63:32]); wr(c*8+3, s[31:0]);
        wr(c*8+4, d[63:32]); wr(c*8+5, d[31:0]);
    endtask

    task automatic model(input int s, input int d, input int cnt, input int code, input bit si, input bit di);
        int w;
        w = 1 << code;
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] tmp [8];
            for (int k = 0; k < w; k++) tmp[k] = expm[(s + k) & 12'hfff];
            for (int k = 0; k < w; k++) expm[(d + k) & 12'hfff] = tmp[k];
            if (si) s += w;
            if (di) d += w;
        end
    endtask

    task automatic wait_done(input int c, output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int t = 0; t < 4000 && !ok; t++) begin
            rd(32, s);
            if (s[c]) ok = 1;
        end
    endtask

    task automatic cmp_mem(input string tag);
        int bad;
        int first;
        bad = 0; first = -1;
        for (int i = 0; i < 4096; i++)
            if (mem[i] !== expm[i]) begin bad++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        check(bad == 0, tag, 64'(mem[first]), 64'(expm[first]));
    endtask

    task automatic mon_reset(input logic [1:0] code, input bit on, input bit hi, input logic [31:0] shi, input logic [31:0] dhi);
        acc_cnt = 0; mon_err = 0; exp_we = 0;
        exp_code = code; mon_on = on; mon_hi = hi; mon_shi = shi; mon_dhi = dhi;
    endtask

    // one complete single-channel transfer with all checks
    task automatic run_xfer(input string tag, input int c, input int slo, input logic [31:0] shi,
                            input int dlo, input logic [31:0] dhi, input logic [31:0] cnt_reg,
                            input int code, input bit si, input bit di, input logic [3:0] low);
        logic [31:0] ctrl, r;
        bit ok;
        int cnt;
        cnt = int'(cnt_reg[15:0]);
        setup(c, {shi, 32'(slo)}, {dhi, 32'(dlo)}, cnt_reg);
        model(slo, dlo, cnt, code, si, di);
        mon_reset(2'(code), 1, 1, shi, dhi);
        ctrl = 32'h8000_0000 | (32'(code) << 25) | (32'(di) << 24) | (32'(si) << 23) | 32'(low);
        wr(c*8, ctrl);
        wait_done(c, ok);
        check(ok, {tag, " R9 done flag"}, 64'(ok), 64'd1);
        cmp_mem({tag, " R5 memory image"});
        check(mon_err == 0, {tag, " R4/R7 beat monitor"}, 64'(mon_err), 64'd0);
        check(acc_cnt == 2*cnt, {tag, " R7 beat count"}, 64'(acc_cnt), 64'(2*cnt));
        rd(c*8, r);
        check(r == (ctrl & 32'h7fff_ffff), {tag, " R9 enable cleared"}, 64'(r), 64'(ctrl & 32'h7fff_ffff));
        wr(32, 32'(1) << c);
        rd(32, r);
        check(r == 0, {tag, " R9 status clear"}, 64'(r), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int ord [4];
        int seq;
        void'($urandom(32'h0d3a_5eed));
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'($urandom);
            expm[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        check(mem_req == 1'b0, "R10 mem_req low", 64'(mem_req), 64'd0);
        rd(32, r); check(r == 0, "R10 status zero", 64'(r), 64'd0);
        rd(0, r);  check(r == 0, "R10 ctrl0 zero", 64'(r), 64'd0);
        rd(27, r); check(r == 0, "R10 ch3 src low zero", 64'(r), 64'd0);

        // R1 register map readback
        wr(2*8+6, 32'hA1B2_C3D4); wr(2*8+7, 32'h1122_3344);
        wr(33, 32'h0000_0F0F); wr(34, 32'h5A5A_0001); wr(35, 32'hC0DE_0002);
        rd(2*8+6, r); check(r == 32'hA1B2_C3D4, "R1 list hi ch2", 64'(r), 64'hA1B2_C3D4);
        rd(2*8+7, r); check(r == 32'h1122_3344, "R1 list lo ch2", 64'(r), 64'h1122_3344);
        rd(33, r); check(r == 32'h0000_0F0F, "R1 list command", 64'(r), 64'h0F0F);
        rd(34, r); check(r == 32'h5A5A_0001, "R1 sleep", 64'(r), 64'h5A5A_0001);
        rd(35, r); check(r == 32'hC0DE_0002, "R1 polarity", 64'(r), 64'hC0DE_0002);

        // R2 upper/lower word independence
        wr(1*8+2, 32'hAAAA_0001); wr(1*8+3, 32'hBBBB_0002); wr(1*8+2, 32'hCCCC_0003);
        rd(1*8+3, r); check(r == 32'hBBBB_0002, "R2 low kept", 64'(r), 64'hBBBB_0002);
        rd(1*8+2, r); check(r == 32'hCCCC_0003, "R2 high replaced", 64'(r), 64'hCCCC_0003);
        wr(1*8+5, 32'h0000_0100); wr(1*8+4, 32'h0000_0009); wr(1*8+5, 32'h0000_0200);
        rd(1*8+4, r); check(r == 32'h9, "R2 dst high kept", 64'(r), 64'h9);

        // R3 control write without enable
        setup(2, 64'h300, 64'h400, 32'd5);
        mon_reset(0, 0, 0, 0, 0);
        wr(2*8, 32'h0180_0000);
        repeat (40) @(negedge clk);
        check(acc_cnt == 0, "R3 no traffic without enable", 64'(acc_cnt), 64'd0);
        rd(32, r); check(r == 0, "R3 no done without enable", 64'(r), 64'd0);

        // R4 little-endian lane order, width 4
        mem[12'h100] = 8'h11; mem[12'h101] = 8'h22; mem[12'h102] = 8'h33; mem[12'h103] = 8'h44;
        for (int k = 0; k < 4; k++) expm[12'h100 + k] = mem[12'h100 + k];
        run_xfer("R4 le", 0, 12'h100, 32'h0, 12'h180, 32'h0, 32'd1, 2, 1, 1, 4'h0);
        check(last_wdata == 64'h4433_2211, "R4 little-endian wdata", last_wdata, 64'h4433_2211);

        // R5 directed hold modes
        run_xfer("R5 src hold", 1, 12'h200, 32'h0000_0007, 12'h240, 32'h0000_0008, 32'd6, 1, 0, 1, 4'h5);
        run_xfer("R5 dst hold", 3, 12'h280, 32'h1234_0000, 12'h2c0, 32'h0, 32'd5, 3, 1, 0, 4'h0);

        // R6 count zero and count field width
        run_xfer("R6 zero count", 2, 12'h500, 32'h0, 12'h540, 32'h0, 32'h0000_0000, 0, 1, 1, 4'h1);
        run_xfer("R6 low 16 bits", 0, 12'h580, 32'h0, 12'h5c0, 32'h0, 32'h0001_0003, 0, 1, 1, 4'h0);

        // random transfers (R4 R5 R7 R9)
        for (int it = 0; it < 10; it++) begin
            int c, code, cnt;
            bit si, di;
            c = $urandom % 4; code = $urandom % 4; cnt = 1 + $urandom % 8;
            si = 1'($urandom); di = 1'($urandom);
            run_xfer("R5 random", c, int'($urandom % 12'h700), $urandom,
                     int'($urandom % 12'h700), $urandom, 32'(cnt), code, si, di, 4'($urandom));
        end

        // R8 fixed priority
        setup(1, 64'h900, 64'ha00, 32'd4);
        setup(3, 64'hb00, 64'hc00, 32'd4);
        setup(0, 64'h800, 64'hd00, 32'd40);
        model(12'h800, 12'hd00, 40, 0, 1, 1);
        model(12'h900, 12'ha00, 4, 0, 1, 1);
        model(12'hb00, 12'hc00, 4, 0, 1, 1);
        mon_reset(0, 0, 0, 0, 0);
        wr(0, 32'h8180_0000);
        wr(3*8, 32'h8180_0000);
        wr(1*8, 32'h8180_0000);
        ord[0] = -1; ord[1] = -1; ord[2] = -1; ord[3] = -1;
        seq = 0;
        for (int t = 0; t < 4000 && (ord[0] < 0 || ord[1] < 0 || ord[3] < 0); t++) begin
            rd(32, r);
            for (int k = 0; k < 4; k++) if (r[k] && ord[k] < 0) begin ord[k] = seq; seq++; end
        end
        check(ord[0] == 0, "R8 channel 0 first", 64'(ord[0]), 64'd0);
        check(ord[1] == 1, "R8 channel 1 second", 64'(ord[1]), 64'd1);
        check(ord[3] == 2, "R8 channel 3 last", 64'(ord[3]), 64'd2);
        cmp_mem("R8 memory image");
        check(mon_err == 0, "R8 R7 beat alternation", 64'(mon_err), 64'd0);
        wr(32, 32'hf);
        rd(32, r); check(r == 0, "R9 status all cleared", 64'(r), 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule